// File: doc/BRIEF.md
# FIFO-Buffered SPI Master Controller

This block is a serial peripheral interface master that software drives through a small word-addressed register file. Words written to the data port queue in a transmit FIFO, are shifted out most-significant bit first on `mosi`, and the bits clocked in on `miso` over the same clock cycles are collected into a receive FIFO that software drains by reading the same data port. The word size, clock polarity, which clock edge launches data and where in the bit the input is sampled are all programmable. The serial clock comes from a 9-bit divider of the system clock.

Every register occupies a 16-byte group. Each group answers at four aliases: a plain write, a clear-bits write, a set-bits write and an invert-bits write, so that software can change single fields without a read-modify-write. Both FIFOs hold a fixed number of bytes, so the number of words they can hold grows as the word size shrinks. An optional automatic select output stays low as long as the transmit FIFO still holds a word that has not finished shifting, and the status register reports both fill levels and a sticky flag for a lost receive word.

Top module: `spi_fifo_master`

## Requirements
- R1: Groups sit at byte addresses 0x00 (control), 0x10 (status), 0x20 (data), 0x30 (divider); 0x40 reads zero. Offset +0x0 writes the value, +0x4 clears the 1 bits, +0x8 sets them, +0xC inverts them. Reads return the plain value, and only control bits 5, 6, 8, 9, 10, 11, 15, 16 and 28 are stored (others read 0).
- R2: The divider keeps the low 9 bits of what is written. Each half of a bit lasts div+1 clocks, so a word of W bits takes 2·W·(div+1) clocks once it starts, and an idle engine starts a queued word on the clock after it becomes visible.
- R3: Control bits 11:10 pick the word size: 0 gives 8 bits, 1 gives 16, 2 or 3 give 32. The low W bits of a written word go out MSB first, and received words are zero-extended.
- R4: With control bit 16 set each FIFO holds 16 bytes (16, 8 or 4 words); with it clear each holds one word. A data write to a full transmit FIFO is dropped.
- R5: Status bits 20:16 give the transmit level in words, including the word being shifted, and bits 28:24 give the receive level.
- R6: Control bit 6 is the idle level of `sck`. With bit 8 set the data changes on the active-to-idle edge (the first bit is driven before the first active edge); with it clear the data changes on the idle-to-active edge. Each word produces exactly W active edges.
- R7: With control bit 9 clear `miso` is sampled at the middle of each bit; with it set, at the end of the bit.
- R8: A word that completes while the receive FIFO is full is discarded and sets status bit 6. The flag stays set until a 1 is written to bit 6 at the status clear alias (0x14); other status writes have no effect.
- R9: With control bit 28 set, `ss_n` is low while bits 15 and 5 are set and the transmit level is non-zero. With bit 28 clear, `ss_n` stays high.
- R10: Shifting happens only while control bit 15 (module on) and bit 5 (master) are both set. While bit 15 is clear both FIFOs are empty, writes to the data port are dropped, and `sck` sits at its idle level; the other control bits keep their values.
- R11: Writing the data port at 0x20 pushes a word and writes to its aliases push nothing. Reading 0x20 pops the oldest received word; reading it while the FIFO is empty returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte address bits 6:2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Automatic active-low select |

## Verification
The assertions watch on every cycle that the overflow flag survives anything other than a clear-alias write, that turning the module off empties both FIFOs, that the clock rests at its idle level whenever no word is shifting, that the select line is low through every shifted word, and that the receive level never exceeds the FIFO size or jumps by more than one. Only the bench scenarios can show the serial results: the word returned through a loopback for each size and clock mode, the mid-bit against end-of-bit sampling, the exact length of a word, MSB-first order, the capacity per word size and the loss of a word on overflow.

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int FIFO_BYTES = 16,
  parameter int DIV_W      = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [6:2]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic        ss_n
);

  localparam int PW = $clog2(FIFO_BYTES);
  localparam int LW = PW + 1;
  localparam logic [31:0] CTRL_MASK = 32'h1001_8F60;

  logic [31:0]      ctrl;
  logic [DIV_W-1:0] baud;
  logic             ovf;

  logic [31:0] tx_mem [FIFO_BYTES];
  logic [31:0] rx_mem [FIFO_BYTES];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [LW-1:0] tx_lvl, rx_lvl, cap;

  logic             busy, half, samp;
  logic [DIV_W-1:0] cnt;
  logic [4:0]       bitn, wm1;
  logic [1:0]       wl;
  logic [31:0]      txsh, rxsh, wmask, rx_word, status_w;

  logic [2:0] grp;
  logic [1:0] op;
  logic wr, rd, on, run, tick, last, bit_in;
  logic push_tx, pop_rx, push_rx, ovf_set, start;

  assign grp = bus_addr[6:4];
  assign op  = bus_addr[3:2];
  assign wr  = bus_sel & bus_we;
  assign rd  = bus_sel & ~bus_we;
  assign on  = ctrl[15];
  assign run = on & ctrl[5];

  assign wl    = (ctrl[11:10] == 2'd0) ? 2'd0 : (ctrl[11:10] == 2'd1) ? 2'd1 : 2'd2;
  assign wm1   = {wl == 2'd2, wl != 2'd0, 3'b111};
  assign wmask = 32'hFFFF_FFFF >> (5'd31 - wm1);
  assign cap   = ctrl[16] ? LW'(FIFO_BYTES >> wl) : LW'(1);

  assign tick    = busy & (cnt == baud);
  assign last    = tick & half & (bitn == wm1);
  assign bit_in  = ctrl[9] ? miso : samp;
  assign rx_word = {rxsh[30:0], bit_in} & wmask;

  assign push_tx = wr & (grp == 3'd2) & (op == 2'd0) & on & (tx_lvl < cap);
  assign pop_rx  = rd & (grp == 3'd2) & (op == 2'd0) & (rx_lvl != '0);
  assign push_rx = last & (rx_lvl < cap);
  assign ovf_set = last & ~(rx_lvl < cap);
  assign start   = run & ~busy & (tx_lvl != '0);

  function automatic logic [31:0] upd(input logic [31:0] o, input logic [31:0] w,
                                      input logic [1:0] k);
    case (k)
      2'd0:    return w;
      2'd1:    return o & ~w;
      2'd2:    return o | w;
      default: return o ^ w;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      baud <= '0;
      ovf  <= 1'b0;
    end else begin
      if (wr && grp == 3'd0) ctrl <= upd(ctrl, bus_wdata, op) & CTRL_MASK;
      if (wr && grp == 3'd3) baud <= DIV_W'(upd(32'(baud), bus_wdata, op));
      if (ovf_set) ovf <= 1'b1;
      else if (wr && grp == 3'd1 && op == 2'd1 && bus_wdata[6]) ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !on) begin
      tx_wp <= '0; tx_rp <= '0; tx_lvl <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_lvl <= '0;
    end else begin
      if (push_tx) tx_wp <= tx_wp + 1'b1;
      if (last)    tx_rp <= tx_rp + 1'b1;
      tx_lvl <= tx_lvl + LW'(push_tx) - LW'(last);
      if (push_rx) rx_wp <= rx_wp + 1'b1;
      if (pop_rx)  rx_rp <= rx_rp + 1'b1;
      rx_lvl <= rx_lvl + LW'(push_rx) - LW'(pop_rx);
    end
  end

  always_ff @(posedge clk) begin
    if (push_tx) tx_mem[tx_wp] <= bus_wdata;
    if (push_rx) rx_mem[rx_wp] <= rx_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; half <= 1'b0; samp <= 1'b0;
      cnt  <= '0;   bitn <= '0;
      txsh <= '0;   rxsh <= '0;
    end else if (!run) begin
      busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      half <= 1'b0;
      cnt  <= '0;
      bitn <= '0;
      txsh <= tx_mem[tx_rp];
    end else if (busy) begin
      if (tick) begin
        cnt <= '0;
        if (!half) begin
          half <= 1'b1;
          samp <= miso;
        end else begin
          half <= 1'b0;
          rxsh <= {rxsh[30:0], bit_in};
          txsh <= {txsh[30:0], 1'b0};
          bitn <= bitn + 1'b1;
          if (bitn == wm1) busy <= 1'b0;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    status_w = '0;
    status_w[16 +: LW] = tx_lvl;
    status_w[24 +: LW] = rx_lvl;
    status_w[6] = ovf;
  end

  always_comb begin
    bus_rdata = '0;
    case (grp)
      3'd0: bus_rdata = ctrl;
      3'd1: bus_rdata = status_w;
      3'd2: if (op == 2'd0 && rx_lvl != '0) bus_rdata = rx_mem[rx_rp];
      3'd3: bus_rdata = 32'(baud);
      default: bus_rdata = '0;
    endcase
  end

  assign sck  = ctrl[6] ^ (busy & ~(half ^ ctrl[8]));
  assign mosi = busy & txsh[wm1];
  assign ss_n = ~(ctrl[28] & run & (tx_lvl != '0));

endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int LW         = 5,
  parameter int FIFO_BYTES = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [6:2]    bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          sck,
  input logic          ss_n,
  input logic [31:0]   ctrl,
  input logic          busy,
  input logic          ovf,
  input logic [LW-1:0] tx_lvl,
  input logic [LW-1:0] rx_lvl
);

  // R8: only a clear-alias write with bit 6 drops the flag
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !(bus_sel && bus_we && bus_addr == 5'b00101 && bus_wdata[6]) |=> ovf);

  // R10: module off empties both FIFOs
  a_r10_off_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[15] |=> (tx_lvl == '0) && (rx_lvl == '0));

  // R6: clock rests at idle level when nothing shifts
  a_r6_idle_sck: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == ctrl[6]);

  // R9: select held low through every shifted word
  a_r9_ss_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ctrl[28] && ctrl[15] && ctrl[5] |-> !ss_n);

  // R4: receive level bounded by storage
  a_r4_rx_cap: assert property (@(posedge clk) disable iff (!rst_n)
    rx_lvl <= LW'(FIFO_BYTES) && tx_lvl <= LW'(FIFO_BYTES));

  // R5: receive level moves one word at a time except on flush
  a_r5_level_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rx_lvl == $past(rx_lvl)) || (rx_lvl == $past(rx_lvl) + 1'b1) ||
             (rx_lvl + 1'b1 == $past(rx_lvl)) || (rx_lvl == '0));

endmodule

bind spi_fifo_master spi_fifo_master_chk #(.LW(LW), .FIFO_BYTES(FIFO_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sck(sck), .ss_n(ss_n),
  .ctrl(ctrl), .busy(busy), .ovf(ovf), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl)
);

// File: tb/spi_fifo_master_test.sv
module spi_fifo_master_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [6:2]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sck, mosi, miso, ss_n;
  logic        probe = 1'b0, ckp_cur = 1'b0;

  int checks = 0, errors = 0;
  int act_cnt = 0, ss_cnt = 0;
  logic first_seen = 1'b0, first_mosi = 1'b0, sck_q = 1'b0;

  always #2.5 clk = ~clk;

  assign miso = probe ? (sck ^ ckp_cur) : mosi;

  spi_fifo_master uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  always @(negedge clk) begin
    if (sck !== sck_q && sck !== ckp_cur) begin
      act_cnt++;
      if (!first_seen) begin
        first_seen = 1'b1;
        first_mosi = mosi;
      end
    end
    sck_q = sck;
    if (ss_n === 1'b0) ss_cnt++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a[6:2]; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a[6:2];
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wait_rx(input int n);
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      rd(7'h10, v);
      if (int'(v[28:24]) >= n) break;
    end
  endtask

  // {probe, wsz, ckp, cke, smp, div[7:0], data, expected}
  localparam logic [77:0] VEC [8] = '{
    {1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 8'd0, 32'h0000_00A5, 32'h0000_00A5},
    {1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 8'd2, 32'h1234_C3E1, 32'h0000_C3E1},
    {1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 8'd1, 32'h80F0_0F01, 32'h80F0_0F01},
    {1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 8'd0, 32'h5A5A_1234, 32'h5A5A_1234},
    {1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 8'd1, 32'h0000_003C, 32'h0000_0000},
    {1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 8'd1, 32'h0000_003C, 32'h0000_00FF},
    {1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 8'd0, 32'h0000_7777, 32'h0000_FFFF},
    {1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 8'd0, 32'h0000_7777, 32'h0000_0000}
  };

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(7'h00, v); check("R1 ctrl reset", v, 32'h0);
    rd(7'h10, v); check("R5 status reset", v, 32'h0);
    check("R9 ss_n reset", 32'(ss_n), 32'h1);
    check("R6 sck reset", 32'(sck), 32'h0);
    rd(7'h20, v); check("R11 empty read", v, 32'h0);

    // aliases and masks
    wr(7'h00, 32'hFFFF_FFFF); rd(7'h00, v); check("R1 plain mask", v, 32'h1001_8F60);
    wr(7'h04, 32'h0000_8000); rd(7'h00, v); check("R1 clear alias", v, 32'h1001_0F60);
    wr(7'h08, 32'h8000_0000); rd(7'h00, v); check("R1 set unimpl", v, 32'h1001_0F60);
    wr(7'h0C, 32'h0000_0060); rd(7'h00, v); check("R1 invert alias", v, 32'h1001_0F00);
    wr(7'h00, 32'h0);
    rd(7'h40, v); check("R1 reserved group", v, 32'h0);
    wr(7'h30, 32'hFFFF_FFFF); rd(7'h30, v); check("R2 divider 9 bits", v, 32'h1FF);

    // table of loopback and sampling vectors
    for (int i = 0; i < 8; i++) begin
      logic [77:0] e;
      int ww, dv;
      e = VEC[i];
      ww = (e[76:75] == 2'd0) ? 8 : (e[76:75] == 2'd1) ? 16 : 32;
      dv = int'(e[71:64]);
      probe = e[77];
      ckp_cur = e[74];
      wr(7'h00, 32'h0);
      wr(7'h30, 32'(e[71:64]));
      wr(7'h00, 32'h1001_8020 | (32'(e[76:75]) << 10) | (32'(e[74]) << 6) |
                (32'(e[73]) << 8) | (32'(e[72]) << 9));
      @(negedge clk);
      act_cnt = 0; ss_cnt = 0; first_seen = 1'b0;
      wr(7'h20, e[63:32]);
      wait_rx(1);
      rd(7'h20, v);
      check($sformatf("R3 R7 vec%0d word", i), v, e[31:0]);
      check($sformatf("R6 vec%0d active edges", i), act_cnt, ww);
      check($sformatf("R3 vec%0d msb first", i), 32'(first_mosi), 32'(e[32 + ww - 1]));
      check($sformatf("R2 R9 vec%0d select length", i), ss_cnt, 1 + 2 * ww * (dv + 1));
      check($sformatf("R6 vec%0d idle level", i), 32'(sck), 32'(e[74]));
    end
    probe = 1'b0;
    ckp_cur = 1'b0;

    // capacity per word size, master off
    wr(7'h00, 32'h0);
    wr(7'h00, 32'h0001_8000);
    for (int k = 0; k < 20; k++) wr(7'h20, 32'(k));
    wr(7'h28, 32'h55);
    repeat (20) @(negedge clk);
    rd(7'h10, v); check("R4 R11 8-bit cap", v, 32'h0010_0000);
    check("R10 no shift without master", 32'(sck), 32'h0);
    wr(7'h04, 32'h0000_8000);
    rd(7'h10, v); check("R10 off flush", v, 32'h0);
    rd(7'h00, v); check("R10 config kept", v, 32'h0001_0000);
    wr(7'h20, 32'h1);
    rd(7'h10, v); check("R10 push dropped off", v, 32'h0);
    wr(7'h00, 32'h0001_8800);
    for (int k = 0; k < 6; k++) wr(7'h20, 32'(k));
    rd(7'h10, v); check("R4 32-bit cap", v, 32'h0004_0000);
    wr(7'h00, 32'h0);
    wr(7'h00, 32'h0000_8000);
    for (int k = 0; k < 3; k++) wr(7'h20, 32'(k));
    rd(7'h10, v); check("R4 single entry", v, 32'h0001_0000);

    // overflow, automatic select disabled
    wr(7'h00, 32'h0);
    wr(7'h30, 32'h0);
    wr(7'h00, 32'h0001_8820);
    @(negedge clk);
    ss_cnt = 0;
    wr(7'h20, 32'hA000_0001);
    wr(7'h20, 32'hB000_0002);
    wr(7'h20, 32'hC000_0003);
    wr(7'h20, 32'hD000_0004);
    wait_rx(4);
    wr(7'h20, 32'hE000_0005);
    repeat (100) @(negedge clk);
    rd(7'h10, v); check("R8 overflow status", v, 32'h0400_0040);
    check("R9 select unused", ss_cnt, 0);
    wr(7'h18, 32'h0000_0040);
    wr(7'h10, 32'h0);
    rd(7'h10, v); check("R8 flag sticky", v, 32'h0400_0040);
    rd(7'h20, v); check("R11 pop 1", v, 32'hA000_0001);
    rd(7'h20, v); check("R11 pop 2", v, 32'hB000_0002);
    rd(7'h20, v); check("R11 pop 3", v, 32'hC000_0003);
    rd(7'h20, v); check("R8 pop 4 not lost word", v, 32'hD000_0004);
    wr(7'h14, 32'h0000_0040);
    rd(7'h10, v); check("R8 flag cleared", v, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule